// File: doc/BRIEF.md
# Standby-Rail Reset Supervisor with Power-Good Delay

This block is a clocked model of the supervisor that watches a standby supply rail and drives an active-low reset line. An analog comparator reports whether the rail is in regulation (`rail_ok`), and a second flag reports whether the supply is in undervoltage lockout (`uvlo`). The block holds the reset line low until the rail has been good for a programmable delay. A counter replaces the external timing capacitor. Once the line is released, a short deglitch window filters brief rail dips before the line is asserted again.

The controller has four named states:
- **HOLD** drives the reset low, with no timer running.
- **COUNT** drives the reset low while the power-good delay runs.
- **RUN** releases the reset.
- **FILTER** keeps the reset released while a rail dip is timed.

The named transitions are:
- *arm* (HOLD→COUNT): the rail is good and UVLO is clear.
- *abort* (COUNT→HOLD): the rail drops or UVLO is set.
- *release* (COUNT→RUN): the delay has expired.
- *dip* (RUN→FILTER): the rail drops.
- *recover* (FILTER→RUN): the rail returns within the window.
- *trip* (FILTER→HOLD): the dip outlasts the window.
- *lockout* (RUN or FILTER→HOLD): UVLO is set.

Both counters clear whenever their state is left, so every delay starts from zero. The block samples the level of the reset line itself (`line_sense`). A low level driven by another device does not start a delay.

Top module: `rail_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `nrst_o` is 0 and `delay_busy` is 0.
- R2: While `rail_ok` is sampled 0 and the line has not yet been released, `nrst_o` stays 0.
- R3: A clock edge that samples `uvlo`=1 makes `nrst_o` 0 after that edge, whatever `rail_ok` is.
- R4: `nrst_o` rises after `DELAY_CYCLES`+1 consecutive edges that sample `rail_ok`=1 and `uvlo`=0. `delay_busy` is 1 from the first of those edges until the release.
- R5: If `rail_ok` drops during the delay, the count clears and `nrst_o` stays 0. A later release needs a full new run of `DELAY_CYCLES`+1 good samples.
- R6: After each release and later assertion, the next release again needs the full `DELAY_CYCLES`+1 good samples.
- R7: Once released, `nrst_o` falls after `GLITCH_CYCLES`+1 consecutive edges that sample `rail_ok`=0.
- R8: A dip of `GLITCH_CYCLES` or fewer low samples leaves `nrst_o` at 1. The deglitch count restarts at the next dip.
- R9: `line_sense`=0 while released does not start a delay: `delay_busy` stays 0 and `nrst_o` stays 1.
- R10: `delay_busy` is 1 only while `nrst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| rail_ok | input | 1 | Standby rail in regulation (comparator flag) |
| uvlo | input | 1 | Supply in undervoltage lockout |
| line_sense | input | 1 | Sensed level of the shared reset line |
| nrst_o | output | 1 | Active-low reset drive (1 = released) |
| delay_busy | output | 1 | Power-good delay timer running (test visibility) |

## Verification
The rail flag is driven through several patterns:
- **Steady rail.** A long good run measures the exact release latency.
- **Early drop.** A run cut short inside the delay shows that the count clears rather than pauses.
- **Short dip.** A dip of exactly the window length separates a correct deglitch threshold from an off-by-one.
- **Long dip.** A dip one sample longer shows that the line does trip.

UVLO pulses are applied both during the count and while released, to show that lockout wins over a good rail. Pulling the sensed line low while released shows that an outside assertion does not arm the timer. A second full power-up cycle confirms that each delay starts from zero.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_RUN    = 2'd2,
        ST_FILTER = 2'd3
    } sup_state_t;
endpackage

// File: rtl/sup_window_cnt.sv
module sup_window_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R6
    cnt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/sup_ctrl_fsm.sv
module sup_ctrl_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rail_ok,
    input  logic       uvlo,
    input  logic       delay_done,
    input  logic       glitch_done,
    output sup_state_t state
);
    sup_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (rail_ok && !uvlo) nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (uvlo || !rail_ok) nxt = ST_HOLD;
                else if (delay_done)  nxt = ST_RUN;
            end
            ST_RUN: begin
                if (uvlo)          nxt = ST_HOLD;
                else if (!rail_ok) nxt = ST_FILTER;
            end
            ST_FILTER: begin
                if (uvlo)             nxt = ST_HOLD;
                else if (rail_ok)     nxt = ST_RUN;
                else if (glitch_done) nxt = ST_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    // R4
    release_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN && $past(state) != ST_FILTER)
            |-> $past(state) == ST_COUNT);
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
    import sup_pkg::*;
#(
    parameter int DELAY_CYCLES  = 64,
    parameter int GLITCH_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_ok,
    input  logic uvlo,
    input  logic line_sense,
    output logic nrst_o,
    output logic delay_busy
);
    sup_state_t state;
    logic       delay_done;
    logic       glitch_done;
    logic       delay_run;
    logic       glitch_run;

    sup_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rail_ok     (rail_ok),
        .uvlo        (uvlo),
        .delay_done  (delay_done),
        .glitch_done (glitch_done),
        .state       (state)
    );

    sup_window_cnt #(.LIMIT(DELAY_CYCLES)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (delay_run),
        .done  (delay_done)
    );

    sup_window_cnt #(.LIMIT(GLITCH_CYCLES)) u_glitch (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (glitch_run),
        .done  (glitch_done)
    );

    always_comb begin
        delay_run  = 1'b0;
        glitch_run = 1'b0;
        nrst_o     = 1'b0;
        delay_busy = 1'b0;
        unique case (state)
            ST_HOLD:   ;
            ST_COUNT:  begin delay_run = 1'b1; delay_busy = 1'b1; end
            ST_RUN:    nrst_o = 1'b1;
            ST_FILTER: begin glitch_run = 1'b1; nrst_o = 1'b1; end
        endcase
    end

    // R3
    uvlo_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !nrst_o);
    // R2
    bad_rail_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nrst_o && !rail_ok) |=> !nrst_o);
    // R4
    rise_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nrst_o) |-> $past(delay_busy));
    // R9
    outside_pull_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nrst_o && !line_sense) |=> !delay_busy);
    // R10
    busy_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delay_busy |-> !nrst_o);
endmodule

// File: tb/rail_supervisor_tb_top.sv
module rail_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D = 12;
    localparam int G = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_ok = 1'b0;
    logic uvlo = 1'b0;
    logic line_sense = 1'b1;
    logic nrst_o;
    logic delay_busy;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;
    string req = "R1";

    // behavioural reference state
    bit m_rel = 1'b0;
    int m_good = 0;
    int m_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_supervisor #(.DELAY_CYCLES(D), .GLITCH_CYCLES(G)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_ok    (rail_ok),
        .uvlo       (uvlo),
        .line_sense (line_sense),
        .nrst_o     (nrst_o),
        .delay_busy (delay_busy)
    );

    function automatic void model_step();
        if (!rst_n || uvlo) begin
            m_rel = 1'b0; m_good = 0; m_bad = 0;
        end else if (!m_rel) begin
            m_good = rail_ok ? m_good + 1 : 0;
            if (m_good == D + 1) begin m_rel = 1'b1; m_good = 0; m_bad = 0; end
        end else begin
            m_bad = rail_ok ? 0 : m_bad + 1;
            if (m_bad == G + 1) begin m_rel = 1'b0; m_bad = 0; m_good = 0; end
        end
    endfunction

    task automatic check(input string r, input logic act, input logic exp, input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", r, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check(req, nrst_o, m_rel, "nrst_o");
            check(req, delay_busy, (!m_rel && m_good > 0), "delay_busy");
        end
    endtask

    // counts good samples until release, compares against the full delay
    task automatic measure_release(input string r);
        int n = 0;
        rail_ok = 1'b1;
        while (nrst_o !== 1'b1 && n < D + 10) begin
            tick(1);
            n++;
        end
        check(r, (n == D + 1), 1'b1, "release latency");
        if (n != D + 1) $display("  latency %0d vs %0d", n, D + 1);
    endtask

    initial begin
        // R1: reset state
        req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1", nrst_o, 1'b0, "nrst after reset");
        check("R1", delay_busy, 1'b0, "busy after reset");

        // R2: rail bad keeps reset low
        req = "R2";
        tick(10);

        // R3: uvlo overrides a good rail
        req = "R3";
        rail_ok = 1'b1; uvlo = 1'b1;
        tick(D + 4);
        check("R3", nrst_o, 1'b0, "nrst under uvlo");

        // R5: drop during count clears it
        req = "R5";
        uvlo = 1'b0;
        tick(D - 2);
        rail_ok = 1'b0;
        tick(3);
        check("R5", delay_busy, 1'b0, "busy after abort");
        // uvlo during count also aborts
        rail_ok = 1'b1;
        tick(5);
        uvlo = 1'b1; tick(1); uvlo = 1'b0;
        check("R5", delay_busy, 1'b0, "busy after uvlo abort");

        // R4: full run releases after D+1 samples
        req = "R4";
        measure_release("R4");
        tick(3);

        // R8: dip of exactly G samples is filtered, twice
        req = "R8";
        rail_ok = 1'b0; tick(G); rail_ok = 1'b1; tick(2);
        check("R8", nrst_o, 1'b1, "nrst after short dip");
        rail_ok = 1'b0; tick(G); rail_ok = 1'b1; tick(2);
        check("R8", nrst_o, 1'b1, "nrst after second dip");

        // R9: outside pull on the line
        req = "R9";
        line_sense = 1'b0; tick(6);
        check("R9", delay_busy, 1'b0, "busy during outside pull");
        check("R9", nrst_o, 1'b1, "nrst during outside pull");
        line_sense = 1'b1; tick(2);

        // R7: long dip trips
        req = "R7";
        rail_ok = 1'b0; tick(G + 1);
        check("R7", nrst_o, 1'b0, "nrst after long dip");
        tick(3);

        // R6: second power-up needs full delay again
        req = "R6";
        measure_release("R6");
        tick(2);

        // R3: uvlo while released asserts next edge
        req = "R3";
        uvlo = 1'b1; tick(1);
        check("R3", nrst_o, 1'b0, "nrst after uvlo while released");
        uvlo = 1'b0;

        // R10 / R6: third release, busy only while low
        req = "R10";
        measure_release("R6");
        check("R10", delay_busy, 1'b0, "busy while released");
        tick(4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule